// File: doc/BRIEF.md
# Accumulator bit-manipulation unit

This unit takes one 40-bit source accumulator and turns it into a 40-bit destination value in a single registered step. A 4-bit function code and a 4-bit auxiliary code together pick the operation. The operations are arithmetic and logical shifts in both directions, exponent detection, normalization, signed and zero-filled field extraction, field insertion, and joining the source with one of two alternate accumulators. Where an operation needs a shift amount or a field descriptor, it comes from one of four 16-bit auxiliary registers, from the source accumulator itself, or from a 16-bit immediate. Normalization also writes the exponent it found back into the selected auxiliary register, through a one-cycle write strobe.

A small result state machine sits behind the datapath. ST_IDLE means no operation was accepted on the last edge. ST_RESULT means a legal operation was accepted and the result register now holds it. ST_FAULT means an unlisted code pair was presented. The next state depends only on the inputs of the current cycle, and all three states share the same transitions. No op_valid leads to ST_IDLE. op_valid with a legal code leads to ST_RESULT. op_valid with an unlisted code leads to ST_FAULT. Reset enters ST_IDLE.

Top module: `accum_bmu`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, res_valid, illegal and ar_wr_en are 0 and res_acc is 0.
- R2: The register-amount arithmetic shifts are func 0000 (right) and func 0001 (left), with aux 00xx, where xx selects auxiliary register ar0..ar3. The amount is the low 6 bits of that register, read as a signed value. An arithmetic right shift fills with the sign bit and a left shift fills with zeros. The result appears on res_acc, with res_valid high, on the first clock edge after op_valid is sampled high.
- R3: The logical forms are aux 10xx with func 0000 (right) or 0001 (left), using the same register amount as R2. A logical right shift fills with zeros.
- R4: Func 1000 (right) or 1001 (left) takes the signed amount from src_acc[5:0]. Aux 0000 gives the arithmetic form and aux 1000 gives the logical form.
- R5: Func 1100 (right) or 1101 (left) takes the signed amount from imm[5:0]. Aux 0000 gives the arithmetic form and aux 1000 gives the logical form.
- R6: A negative amount shifts by its magnitude in the opposite direction and keeps the fill type of the form. For example, a left shift in arithmetic form with amount -3 is an arithmetic right shift by 3.
- R7: Func 0000 with aux 1100 returns the exponent, zero-extended. The exponent is the number of bits below bit 39 that equal bit 39 before the first bit that differs. It is 39 for an input of all zeros or all ones.
- R8: Func 0001 with aux 11xx returns src_acc shifted left by its exponent. One cycle later it pulses ar_wr_en for that same cycle, with ar_wr_sel = xx and ar_wr_data = the exponent. An input of zero gives a result of 0 and a written value of 39.
- R9: A field descriptor holds the width in bits [15:8] and the start position in bits [7:0]. Extraction takes the field, right-aligns it and fills the bits above it. Signed extraction is func 1110 with aux 0000 (descriptor from imm) or func 0010 with aux 00xx (descriptor from register xx), and fills with the top bit of the field. Zero-filled extraction is 1110/0100 or 0010/01xx and fills with zeros. A width of 0 gives 0.
- R10: Insertion is 1110/1000 (descriptor from imm) or 1010/10xx (descriptor from register xx). The result is dst_acc with the field replaced by the low width bits of src_acc, placed at the start position.
- R11: Func 0111 with aux 0000 returns {src_acc[19:0], alt0_acc[19:0]}. Aux 0001 does the same with alt1_acc.
- R12: Any code pair not listed in R2 to R11 raises illegal for one cycle. In that cycle res_valid and ar_wr_en are 0 and res_acc keeps its previous value.
- R13: In a cycle after op_valid was low, res_valid, illegal and ar_wr_en are 0 and res_acc is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| func | input | 4 | Function code |
| aux | input | 4 | Auxiliary code |
| src_acc | input | 40 | Source accumulator |
| dst_acc | input | 40 | Current destination value, used by insertion |
| alt0_acc | input | 40 | Alternate accumulator 0 |
| alt1_acc | input | 40 | Alternate accumulator 1 |
| ar0 | input | 16 | Auxiliary register 0 |
| ar1 | input | 16 | Auxiliary register 1 |
| ar2 | input | 16 | Auxiliary register 2 |
| ar3 | input | 16 | Auxiliary register 3 |
| imm | input | 16 | Immediate amount or descriptor |
| res_valid | output | 1 | res_acc was updated on the last edge |
| res_acc | output | 40 | Registered destination value |
| illegal | output | 1 | Unlisted code pair seen on the last edge |
| ar_wr_en | output | 1 | Exponent write strobe from normalization |
| ar_wr_sel | output | 2 | Auxiliary register to write |
| ar_wr_data | output | 16 | Exponent to write |

## Verification
A wrong decode or a wrong shift direction shows up on the first edge after the operation. It appears as a wrong res_acc value, or as illegal rising in place of res_valid, so every directed vector is checked exactly one cycle after it is issued. If the result state machine stays in ST_RESULT or ST_FAULT after op_valid falls, res_valid or illegal stays high through an idle cycle, and the hold checks catch it one cycle later. A lost hold of res_acc on a faulting code changes the value the next idle check compares against.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic [2:0] {
        K_SHIFT, K_EXP, K_NORM, K_EXTS, K_EXTZ, K_INS, K_CAT
    } bmu_kind_e;

    typedef enum logic [1:0] {
        OPD_AR, OPD_SELF, OPD_IMM
    } bmu_opd_e;

    typedef struct packed {
        bmu_kind_e  kind;
        bmu_opd_e   opd;
        logic       left;
        logic       arith;
        logic [1:0] ar_idx;
        logic       alt_sel;
        logic       legal;
    } bmu_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RESULT, ST_FAULT
    } bmu_state_e;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [3:0] func,
    input  logic [3:0] aux,
    output bmu_dec_t   dec
);

    always_comb begin
        dec         = '0;
        dec.kind    = K_SHIFT;
        dec.opd     = OPD_AR;
        dec.ar_idx  = aux[1:0];
        dec.alt_sel = aux[0];
        dec.legal   = 1'b1;
        unique casez ({func, aux})
            8'b0000_00??: begin dec.arith = 1'b1; end
            8'b0001_00??: begin dec.arith = 1'b1; dec.left = 1'b1; end
            8'b0000_10??: begin end
            8'b0001_10??: begin dec.left = 1'b1; end
            8'b1000_0000: begin dec.opd = OPD_SELF; dec.arith = 1'b1; end
            8'b1001_0000: begin dec.opd = OPD_SELF; dec.arith = 1'b1; dec.left = 1'b1; end
            8'b1000_1000: begin dec.opd = OPD_SELF; end
            8'b1001_1000: begin dec.opd = OPD_SELF; dec.left = 1'b1; end
            8'b1100_0000: begin dec.opd = OPD_IMM; dec.arith = 1'b1; end
            8'b1101_0000: begin dec.opd = OPD_IMM; dec.arith = 1'b1; dec.left = 1'b1; end
            8'b1100_1000: begin dec.opd = OPD_IMM; end
            8'b1101_1000: begin dec.opd = OPD_IMM; dec.left = 1'b1; end
            8'b0000_1100: begin dec.kind = K_EXP; end
            8'b0001_11??: begin dec.kind = K_NORM; end
            8'b1110_0000: begin dec.kind = K_EXTS; dec.opd = OPD_IMM; end
            8'b0010_00??: begin dec.kind = K_EXTS; end
            8'b1110_0100: begin dec.kind = K_EXTZ; dec.opd = OPD_IMM; end
            8'b0010_01??: begin dec.kind = K_EXTZ; end
            8'b1110_1000: begin dec.kind = K_INS; dec.opd = OPD_IMM; end
            8'b1010_10??: begin dec.kind = K_INS; end
            8'b0111_0000,
            8'b0111_0001: begin dec.kind = K_CAT; end
            default:      begin dec.legal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/bmu_shifter.sv
module bmu_shifter #(
    parameter int ACC_W = 40,
    parameter int AMT_W = 6
) (
    input  logic [ACC_W-1:0] val,
    input  logic [AMT_W-1:0] amt,
    input  logic             left,
    input  logic             arith,
    output logic [ACC_W-1:0] out
);

    logic                    neg;
    logic [AMT_W-1:0]        mag;
    logic                    go_left;
    logic signed [ACC_W-1:0] sval;

    assign neg     = amt[AMT_W-1];
    assign mag     = neg ? (~amt + 1'b1) : amt;
    assign go_left = left ^ neg;
    assign sval    = val;

    always_comb begin
        if (go_left)
            out = val << mag;
        else if (arith)
            out = sval >>> mag;
        else
            out = val >> mag;
    end

endmodule

// File: rtl/bmu_field.sv
module bmu_field #(
    parameter int ACC_W = 40,
    parameter int DSC_W = 16,
    localparam int EXP_W = $clog2(ACC_W)
) (
    input  logic [ACC_W-1:0] src,
    input  logic [ACC_W-1:0] dst,
    input  logic [DSC_W-1:0] desc,
    output logic [ACC_W-1:0] ext_s,
    output logic [ACC_W-1:0] ext_z,
    output logic [ACC_W-1:0] ins,
    output logic [EXP_W-1:0] expo
);

    localparam int HB = DSC_W / 2;
    localparam logic [ACC_W-1:0] ONES = '1;
    localparam logic [ACC_W-1:0] ONE  = ACC_W'(1);

    logic [HB-1:0]    wid;
    logic [HB-1:0]    pos;
    logic [ACC_W-1:0] mask;
    logic [ACC_W-1:0] pmask;
    logic             top_bit;

    assign wid   = desc[DSC_W-1:HB];
    assign pos   = desc[HB-1:0];
    assign mask  = ~(ONES << wid);
    assign pmask = mask << pos;
    assign ext_z = (src >> pos) & mask;
    assign top_bit = (wid != '0) && ((ext_z & (ONE << (wid - 1'b1))) != '0);
    assign ext_s = top_bit ? (ext_z | ~mask) : ext_z;
    assign ins   = (dst & ~pmask) | ((src << pos) & pmask);

    always_comb begin
        logic run;
        expo = '0;
        run  = 1'b1;
        for (int i = ACC_W - 2; i >= 0; i--) begin
            if (run && (src[i] == src[ACC_W-1]))
                expo = expo + 1'b1;
            else
                run = 1'b0;
        end
    end

endmodule

// File: rtl/accum_bmu.sv
module accum_bmu
    import bmu_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int AR_W  = 16,
    parameter int AMT_W = 6,
    localparam int EXP_W = $clog2(ACC_W),
    localparam int HALF  = ACC_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       func,
    input  logic [3:0]       aux,
    input  logic [ACC_W-1:0] src_acc,
    input  logic [ACC_W-1:0] dst_acc,
    input  logic [ACC_W-1:0] alt0_acc,
    input  logic [ACC_W-1:0] alt1_acc,
    input  logic [AR_W-1:0]  ar0,
    input  logic [AR_W-1:0]  ar1,
    input  logic [AR_W-1:0]  ar2,
    input  logic [AR_W-1:0]  ar3,
    input  logic [AR_W-1:0]  imm,
    output logic             res_valid,
    output logic [ACC_W-1:0] res_acc,
    output logic             illegal,
    output logic             ar_wr_en,
    output logic [1:0]       ar_wr_sel,
    output logic [AR_W-1:0]  ar_wr_data
);

    bmu_dec_t         dec;
    bmu_state_e       state_q, state_d;
    logic [AR_W-1:0]  ar_sel_val;
    logic [AR_W-1:0]  operand;
    logic [ACC_W-1:0] sh_out, ext_s, ext_z, ins_out, res_d;
    logic [EXP_W-1:0] expo;

    bmu_decode u_dec (.func(func), .aux(aux), .dec(dec));

    always_comb begin
        unique case (dec.ar_idx)
            2'd0: ar_sel_val = ar0;
            2'd1: ar_sel_val = ar1;
            2'd2: ar_sel_val = ar2;
            default: ar_sel_val = ar3;
        endcase
        unique case (dec.opd)
            OPD_SELF: operand = src_acc[AR_W-1:0];
            OPD_IMM:  operand = imm;
            default:  operand = ar_sel_val;
        endcase
    end

    bmu_shifter #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_sh (
        .val(src_acc), .amt(operand[AMT_W-1:0]),
        .left(dec.left), .arith(dec.arith), .out(sh_out)
    );

    bmu_field #(.ACC_W(ACC_W), .DSC_W(AR_W)) u_fld (
        .src(src_acc), .dst(dst_acc), .desc(operand),
        .ext_s(ext_s), .ext_z(ext_z), .ins(ins_out), .expo(expo)
    );

    always_comb begin
        unique case (dec.kind)
            K_EXP:   res_d = ACC_W'(expo);
            K_NORM:  res_d = src_acc << expo;
            K_EXTS:  res_d = ext_s;
            K_EXTZ:  res_d = ext_z;
            K_INS:   res_d = ins_out;
            K_CAT:   res_d = {src_acc[HALF-1:0],
                              dec.alt_sel ? alt1_acc[HALF-1:0] : alt0_acc[HALF-1:0]};
            default: res_d = sh_out;
        endcase
    end

    // next state: identical transitions from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (!op_valid)      state_d = ST_IDLE;
                else if (dec.legal) state_d = ST_RESULT;
                else                state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_acc    <= '0;
            ar_wr_en   <= 1'b0;
            ar_wr_sel  <= '0;
            ar_wr_data <= '0;
        end else begin
            ar_wr_en <= 1'b0;
            if (state_d == ST_RESULT) begin
                res_acc <= res_d;
                if (dec.kind == K_NORM) begin
                    ar_wr_en   <= 1'b1;
                    ar_wr_sel  <= dec.ar_idx;
                    ar_wr_data <= AR_W'(expo);
                end
            end
        end
    end

    assign res_valid = (state_q == ST_RESULT);
    assign illegal   = (state_q == ST_FAULT);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dec.legal) |=> res_valid);

    // R12
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dec.legal) |=> (illegal && !ar_wr_en && $stable(res_acc)));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !illegal && !ar_wr_en && $stable(res_acc)));

    // R8
    norm_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_wr_en |-> (res_valid && ((res_acc[ACC_W-1] != res_acc[ACC_W-2]) || (res_acc == '0))));

    // R7
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_wr_en |-> (ar_wr_data < AR_W'(ACC_W)));

endmodule

// File: tb/tb_accum_bmu.sv
module tb_accum_bmu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  func, aux;
    logic [39:0] src_acc, dst_acc, alt0_acc, alt1_acc;
    logic [15:0] ar0, ar1, ar2, ar3, imm;
    logic        res_valid, illegal, ar_wr_en;
    logic [39:0] res_acc;
    logic [1:0]  ar_wr_sel;
    logic [15:0] ar_wr_data;

    int n_chk = 0;
    int n_fail = 0;

    accum_bmu dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] m_shift(logic [39:0] v, logic [5:0] a, bit left, bit arith);
        int n;
        bit l;
        n = (a[5]) ? 64 - int'(a) : int'(a);
        l = left ^ a[5];
        for (int k = 0; k < n; k++)
            v = l ? {v[38:0], 1'b0} : {arith ? v[39] : 1'b0, v[39:1]};
        return v;
    endfunction

    function automatic int m_exp(logic [39:0] v);
        for (int k = 38; k >= 0; k--)
            if (v[k] != v[39]) return 38 - k;
        return 39;
    endfunction

    function automatic logic [39:0] m_ext(logic [39:0] v, logic [15:0] d, bit sgn);
        logic [39:0] r = '0;
        int w = int'(d[15:8]);
        int p = int'(d[7:0]);
        for (int k = 0; k < 40; k++)
            if (k < w && p + k < 40) r[k] = v[p + k];
        if (sgn && w > 0 && w < 40 && r[w-1])
            for (int k = w; k < 40; k++) r[k] = 1'b1;
        return r;
    endfunction

    function automatic logic [39:0] m_ins(logic [39:0] s, logic [39:0] dd, logic [15:0] d);
        int w = int'(d[15:8]);
        int p = int'(d[7:0]);
        for (int k = 0; k < w; k++)
            if (p + k < 40) dd[p + k] = s[k];
        return dd;
    endfunction

    // issue one operation at a falling edge; outputs are sampled one falling edge later
    task automatic issue(logic [3:0] f, logic [3:0] a);
        func = f; aux = a; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_res(string tag, logic [39:0] exp);
        chk({tag, " valid"}, {39'd0, res_valid}, 40'd1);
        chk(tag, res_acc, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; op_valid = 1'b0; func = '0; aux = '0;
        src_acc = '0; dst_acc = '0; alt0_acc = '0; alt1_acc = '0;
        ar0 = '0; ar1 = '0; ar2 = '0; ar3 = '0; imm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 res_valid", {39'd0, res_valid}, 40'd0);
        chk("R1 illegal", {39'd0, illegal}, 40'd0);
        chk("R1 ar_wr_en", {39'd0, ar_wr_en}, 40'd0);
        chk("R1 res_acc", res_acc, 40'd0);
    endtask

    task automatic t_reg_shift;
        src_acc = 40'h80_0000_1234; ar1 = 16'd4; ar2 = 16'd8;
        issue(4'b0000, 4'b0001); expect_res("R2 asr ar1", m_shift(src_acc, 6'd4, 0, 1));
        issue(4'b0001, 4'b0010); expect_res("R2 asl ar2", m_shift(src_acc, 6'd8, 1, 1));
        issue(4'b0000, 4'b1001); expect_res("R3 lsr ar1", m_shift(src_acc, 6'd4, 0, 0));
        issue(4'b0001, 4'b1010); expect_res("R3 lsl ar2", m_shift(src_acc, 6'd8, 1, 0));
    endtask

    task automatic t_self_shift;
        src_acc = 40'hF0_0000_0003;
        issue(4'b1000, 4'b0000); expect_res("R4 asr self", m_shift(src_acc, 6'd3, 0, 1));
        issue(4'b1000, 4'b1000); expect_res("R4 lsr self", m_shift(src_acc, 6'd3, 0, 0));
        issue(4'b1001, 4'b0000); expect_res("R4 asl self", m_shift(src_acc, 6'd3, 1, 1));
    endtask

    task automatic t_imm_shift;
        src_acc = 40'h9A_BCDE_F012; imm = 16'd5;
        issue(4'b1101, 4'b0000); expect_res("R5 asl imm", m_shift(src_acc, 6'd5, 1, 1));
        issue(4'b1100, 4'b1000); expect_res("R5 lsr imm", m_shift(src_acc, 6'd5, 0, 0));
        issue(4'b1100, 4'b0000); expect_res("R5 asr imm", m_shift(src_acc, 6'd5, 0, 1));
    endtask

    task automatic t_negative;
        src_acc = 40'h9A_BCDE_F012; imm = 16'h003D;
        issue(4'b1100, 4'b0000); expect_res("R6 asr by -3", src_acc << 3);
        issue(4'b1101, 4'b0000); expect_res("R6 asl by -3", 40'hF3_579B_DE02);
        issue(4'b1101, 4'b1000); expect_res("R6 lsl by -3", 40'h13_579B_DE02);
    endtask

    task automatic t_exp_norm;
        src_acc = 40'h00_0000_1000;
        issue(4'b0000, 4'b1100); expect_res("R7 exp", 40'd26);
        src_acc = 40'hFF_FFFF_FFFF;
        issue(4'b0000, 4'b1100); expect_res("R7 exp all ones", 40'd39);
        src_acc = 40'hFC_0000_0000;
        issue(4'b0000, 4'b1100); expect_res("R7 exp neg", 40'(m_exp(src_acc)));
        src_acc = 40'h00_0000_1000;
        issue(4'b0001, 4'b1110);
        expect_res("R8 norm", 40'h40_0000_0000);
        chk("R8 wr_en", {39'd0, ar_wr_en}, 40'd1);
        chk("R8 wr_sel", {38'd0, ar_wr_sel}, 40'd2);
        chk("R8 wr_data", {24'd0, ar_wr_data}, 40'd26);
        src_acc = 40'd0;
        issue(4'b0001, 4'b1101);
        expect_res("R8 norm zero", 40'd0);
        chk("R8 zero wr_data", {24'd0, ar_wr_data}, 40'd39);
        chk("R8 zero wr_sel", {38'd0, ar_wr_sel}, 40'd1);
    endtask

    task automatic t_extract;
        src_acc = 40'h00_0000_0FF0; imm = 16'h0804; ar3 = 16'h0804;
        issue(4'b1110, 4'b0000); expect_res("R9 exts imm", 40'hFF_FFFF_FFFF);
        issue(4'b0010, 4'b0111); expect_res("R9 extz ar3", 40'h00_0000_00FF);
        src_acc = 40'h12_3456_789A; imm = 16'h0C08;
        issue(4'b1110, 4'b0100); expect_res("R9 extz imm", m_ext(src_acc, imm, 0));
        ar0 = 16'h0A1A;
        issue(4'b0010, 4'b0000); expect_res("R9 exts ar0", m_ext(src_acc, ar0, 1));
        imm = 16'h0010;
        issue(4'b1110, 4'b0000); expect_res("R9 width zero", 40'd0);
    endtask

    task automatic t_insert;
        src_acc = 40'h00_0000_000A; dst_acc = 40'hFF_FFFF_FFFF; imm = 16'h0408;
        issue(4'b1110, 4'b1000); expect_res("R10 ins imm", 40'hFF_FFFF_FAFF);
        src_acc = 40'h00_0000_1234; dst_acc = 40'h55_5555_5555; ar2 = 16'h101C;
        issue(4'b1010, 4'b1010); expect_res("R10 ins ar2", m_ins(src_acc, dst_acc, ar2));
    endtask

    task automatic t_concat;
        src_acc = 40'hAA_AAA1_2345; alt0_acc = 40'h11_1116_789A; alt1_acc = 40'h22_222B_CDEF;
        issue(4'b0111, 4'b0000); expect_res("R11 cat alt0", 40'h12345_6789A);
        issue(4'b0111, 4'b0001); expect_res("R11 cat alt1", 40'h12345_BCDEF);
    endtask

    task automatic t_illegal;
        logic [39:0] held;
        held = res_acc;
        issue(4'b0011, 4'b0000);
        chk("R12 illegal", {39'd0, illegal}, 40'd1);
        chk("R12 no valid", {39'd0, res_valid}, 40'd0);
        chk("R12 held", res_acc, held);
        issue(4'b0001, 4'b0100);
        chk("R12 illegal 0001/0100", {39'd0, illegal}, 40'd1);
        chk("R12 no write", {39'd0, ar_wr_en}, 40'd0);
        chk("R12 held again", res_acc, held);
    endtask

    task automatic t_idle;
        logic [39:0] held;
        src_acc = 40'h00_0000_0100;
        issue(4'b0001, 4'b1100);
        held = res_acc;
        @(negedge clk);
        chk("R13 idle valid", {39'd0, res_valid}, 40'd0);
        chk("R13 idle write", {39'd0, ar_wr_en}, 40'd0);
        chk("R13 idle illegal", {39'd0, illegal}, 40'd0);
        chk("R13 idle hold", res_acc, held);
    endtask

    initial begin
        #(20 * 20000);
        n_chk++; n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_reg_shift;
        t_self_shift;
        t_imm_shift;
        t_negative;
        t_exp_norm;
        t_extract;
        t_insert;
        t_concat;
        t_illegal;
        t_idle;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule